// File: doc/BRIEF.md
# Bridge Address Window Translator

This block sits inside a bus bridge and decides, for each request, whether the request crosses the bridge and what address it carries on the far side. It holds two banks of three address windows. The primary-side bank claims requests that travel downstream. The secondary-side bank claims requests that travel upstream. Every window has a size-aligned base, a power-of-two size code, an address-space flag (memory or I/O) and a prefetchable flag. Downstream windows also hold an offset that is added to any address they claim.

A request presents an address, a space type and a direction, together with a valid strobe. One clock later the block returns four results: a forward flag, a one-hot vector that names the claiming window, that window's prefetchable flag and the outgoing address. Software programs the windows through a write-only register port. The port selects a side, a window index and a register: 0 selects the base, 1 the attributes, 2 the offset.

Top module: `bridge_win_xlate`

## Requirements
- R1: A result appears exactly one cycle after the request. `rsp_valid` is high in the cycle after `req_valid` was sampled high and low otherwise. While `rsp_valid` is low, `rsp_fwd` is 0 and `rsp_hit` is all zeros.
- R2: After reset every window is disabled, so a request in either direction returns `rsp_fwd`=0. `rsp_valid` is 0 while reset is held.
- R3: The attribute register bits [5:0] hold a size code k. For k from 1 to 20, the window covers 2^(k+11) bytes: code 1 is 4 KB, code 9 is 1 MB and code 19 is 1 GB. An address hits when its bits above bit k+10 equal those bits of the base. Base bits below the window size are ignored.
- R4: A size code of 0 disables the window, whatever its base.
- R5: Attribute bit 9 selects the window's space: 0 for memory, 1 for I/O. A window claims only requests whose `req_io` matches that bit.
- R6: When several windows of the active bank hit, the lowest-numbered window wins. `rsp_hit` has exactly bit i set for winning window i.
- R7: A downstream memory hit returns the request address plus the winning window's offset, modulo 2^32.
- R8: A downstream I/O hit gets the same offset addition.
- R9: An upstream hit returns the request address unchanged. Offset writes to the secondary side have no effect.
- R10: Downstream requests (`req_dir`=0) are decoded only against primary-side windows. Upstream requests (`req_dir`=1) are decoded only against secondary-side windows.
- R11: `rsp_pf` equals attribute bit 8 of the winning window, and is 0 on a miss.
- R12: A request that hits no window returns `rsp_fwd`=0, `rsp_hit`=0 and `rsp_addr` equal to the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_side | input | 1 | 0 = primary (downstream) bank, 1 = secondary (upstream) bank |
| cfg_win | input | 2 | Window index; indices of 3 and above are ignored |
| cfg_reg | input | 2 | 0 = base, 1 = attributes, 2 = offset |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_dir | input | 1 | 0 = downstream, 1 = upstream |
| req_io | input | 1 | 0 = memory, 1 = I/O |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_fwd | output | 1 | Request should be forwarded |
| rsp_hit | output | 3 | One-hot index of the claiming window |
| rsp_pf | output | 1 | Prefetchable flag of the claiming window |
| rsp_addr | output | 32 | Translated outgoing address |

## Verification
The bench uses the default package values: a 32-bit address, three windows per side and a 4 KB minimum window. With these values, one 4 KB window nested inside a 1 MB window on the same base exercises the priority rule. A large offset added to a high address tests wrap-around modulo 2^32. An 8 KB I/O window has boundaries that are cheap to probe on both edges. A 1 GB upstream window checks that the size mask reaches the top bits of the address.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
    localparam int ADDR_W    = 32;
    localparam int NWIN      = 3;
    localparam int MIN_LOG2  = 12;
    localparam int CODE_W    = 6;
    localparam int WIN_IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int PF_BIT    = 8;
    localparam int IO_BIT    = 9;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic { DIR_DOWN = 1'b0, DIR_UP = 1'b1 } dir_e;
    typedef enum logic { SP_MEM = 1'b0, SP_IO = 1'b1 } space_e;
    typedef enum logic [1:0] { REG_BASE = 2'd0, REG_ATTR = 2'd1, REG_OFFS = 2'd2 } creg_e;

    typedef struct packed {
        addr_t  base;
        code_t  code;
        logic   pf;
        space_e sp;
        addr_t  offs;
    } win_cfg_t;

    typedef struct packed {
        logic            valid;
        logic            fwd;
        logic [NWIN-1:0] hit;
        logic            pf;
        addr_t           addr;
    } rsp_t;

    // Mask of the address bits compared for a given size code.
    function automatic addr_t win_mask(code_t code);
        int    sh;
        addr_t m;
        sh = int'(code) + MIN_LOG2 - 1;
        if (sh >= ADDR_W) m = '0;
        else              m = ~((addr_t'(1) << sh) - addr_t'(1));
        return m;
    endfunction

    function automatic logic win_hit(addr_t a, win_cfg_t w, space_e sp);
        return (w.code != '0) && (w.sp == sp) && (((a ^ w.base) & win_mask(w.code)) == '0);
    endfunction
endpackage

// File: rtl/bwt_cfg_bank.sv
module bwt_cfg_bank
    import bwt_pkg::*;
#(
    parameter bit HAS_OFFS = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [WIN_IDX_W-1:0]       idx,
    input  logic [1:0]                 sel,
    input  addr_t                      wdata,
    output win_cfg_t [NWIN-1:0]        cfg_o
);
    for (genvar i = 0; i < NWIN; i++) begin : g_win
        logic wr;
        assign wr = we && (int'(idx) == i);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_o[i].base <= '0;
                cfg_o[i].code <= '0;
                cfg_o[i].pf   <= 1'b0;
                cfg_o[i].sp   <= SP_MEM;
            end else if (wr) begin
                if (sel == REG_BASE) cfg_o[i].base <= wdata;
                if (sel == REG_ATTR) begin
                    cfg_o[i].code <= wdata[CODE_W-1:0];
                    cfg_o[i].pf   <= wdata[PF_BIT];
                    cfg_o[i].sp   <= space_e'(wdata[IO_BIT]);
                end
            end
        end

        if (HAS_OFFS) begin : g_offs
            always_ff @(posedge clk) begin
                if (rst)                           cfg_o[i].offs <= '0;
                else if (wr && sel == REG_OFFS)    cfg_o[i].offs <= wdata;
            end
        end else begin : g_no_offs
            assign cfg_o[i].offs = '0;
        end
    end
endmodule

// File: rtl/bwt_win_match.sv
module bwt_win_match
    import bwt_pkg::*;
(
    input  win_cfg_t [NWIN-1:0] cfg,
    input  addr_t               addr,
    input  space_e              sp,
    output logic [NWIN-1:0]     hit_raw
);
    for (genvar i = 0; i < NWIN; i++) begin : g_cmp
        assign hit_raw[i] = win_hit(addr, cfg[i], sp);
    end
endmodule

// File: rtl/bwt_prio_sel.sv
module bwt_prio_sel
    import bwt_pkg::*;
(
    input  logic [NWIN-1:0] raw,
    output logic [NWIN-1:0] onehot,
    output logic            any
);
    always_comb begin
        onehot = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (raw[i]) onehot = NWIN'(1) << i;
        end
        any = |raw;
    end
endmodule

// File: rtl/bridge_win_xlate.sv
module bridge_win_xlate
    import bwt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_side,
    input  logic [WIN_IDX_W-1:0] cfg_win,
    input  logic [1:0]           cfg_reg,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  logic                 req_valid,
    input  logic                 req_dir,
    input  logic                 req_io,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_fwd,
    output logic [NWIN-1:0]      rsp_hit,
    output logic                 rsp_pf,
    output logic [ADDR_W-1:0]    rsp_addr
);
    win_cfg_t [NWIN-1:0] dn_cfg, up_cfg, act_cfg;
    logic [NWIN-1:0]     raw_hit, win_oh;
    logic                any_hit;
    rsp_t                rsp_d, rsp_q;
    addr_t               offs_sel;
    logic                pf_sel;

    bwt_cfg_bank #(.HAS_OFFS(1'b1)) u_dn_bank (
        .clk(clk), .rst(rst), .we(cfg_we && cfg_side == 1'b0),
        .idx(cfg_win), .sel(cfg_reg), .wdata(cfg_wdata), .cfg_o(dn_cfg)
    );

    bwt_cfg_bank #(.HAS_OFFS(1'b0)) u_up_bank (
        .clk(clk), .rst(rst), .we(cfg_we && cfg_side == 1'b1),
        .idx(cfg_win), .sel(cfg_reg), .wdata(cfg_wdata), .cfg_o(up_cfg)
    );

    assign act_cfg = (dir_e'(req_dir) == DIR_UP) ? up_cfg : dn_cfg;

    bwt_win_match u_match (
        .cfg(act_cfg), .addr(req_addr), .sp(space_e'(req_io)), .hit_raw(raw_hit)
    );

    bwt_prio_sel u_prio (
        .raw(raw_hit), .onehot(win_oh), .any(any_hit)
    );

    always_comb begin
        offs_sel = '0;
        pf_sel   = 1'b0;
        for (int i = 0; i < NWIN; i++) begin
            if (win_oh[i]) begin
                offs_sel = offs_sel | act_cfg[i].offs;
                pf_sel   = pf_sel | act_cfg[i].pf;
            end
        end
        rsp_d.valid = req_valid;
        rsp_d.fwd   = req_valid && any_hit;
        rsp_d.hit   = req_valid ? win_oh : '0;
        rsp_d.pf    = req_valid && pf_sel;
        rsp_d.addr  = any_hit ? req_addr + offs_sel : req_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fwd   = rsp_q.fwd;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_pf    = rsp_q.pf;
    assign rsp_addr  = rsp_q.addr;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_fwd && rsp_hit == '0));
    // R6
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0(rsp_hit));
    // R12
    fwd_hit_agree_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fwd == (rsp_hit != '0)));
    // R9
    up_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dir) |=> (rsp_addr == $past(req_addr)));
    // R11
    miss_no_pf_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fwd) |-> !rsp_pf);
endmodule

// File: tb/bridge_win_xlate_tb.sv
module bridge_win_xlate_tb;
    import bwt_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_side = 1'b0;
    logic [1:0]  cfg_win = '0, cfg_reg = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_dir = 1'b0, req_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_fwd, rsp_pf;
    logic [2:0]  rsp_hit;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bridge_win_xlate u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_win(cfg_win),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_dir(req_dir),
        .req_io(req_io), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd),
        .rsp_hit(rsp_hit), .rsp_pf(rsp_pf), .rsp_addr(rsp_addr)
    );

    typedef struct packed {
        logic        dir;
        logic        io;
        logic [31:0] addr;
        logic        fwd;
        logic [2:0]  hit;
        logic        pf;
        logic [31:0] xaddr;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 32'h8000_0ABC, 1'b1, 3'b001, 1'b0, 32'h9000_0ABC}, // R6 R7 nested
        '{1'b0, 1'b0, 32'h8001_2345, 1'b1, 3'b010, 1'b1, 32'h7001_2345}, // R7 wrap R11
        '{1'b0, 1'b0, 32'h800F_FFFF, 1'b1, 3'b010, 1'b1, 32'h700F_FFFF}, // R3 top edge
        '{1'b0, 1'b0, 32'h8010_0000, 1'b0, 3'b000, 1'b0, 32'h8010_0000}, // R12 past edge
        '{1'b0, 1'b1, 32'h0000_C123, 1'b1, 3'b100, 1'b0, 32'h0000_C223}, // R8
        '{1'b0, 1'b1, 32'h0000_DFFF, 1'b1, 3'b100, 1'b0, 32'h0000_E0FF}, // R8 R3 edge
        '{1'b0, 1'b1, 32'h0000_E000, 1'b0, 3'b000, 1'b0, 32'h0000_E000}, // R3 R12
        '{1'b0, 1'b0, 32'h0000_C123, 1'b0, 3'b000, 1'b0, 32'h0000_C123}, // R5
        '{1'b0, 1'b1, 32'h8000_0010, 1'b0, 3'b000, 1'b0, 32'h8000_0010}, // R5
        '{1'b1, 1'b0, 32'h0010_FFFF, 1'b1, 3'b001, 1'b1, 32'h0010_FFFF}, // R9 R11
        '{1'b1, 1'b0, 32'h2000_0004, 1'b0, 3'b000, 1'b0, 32'h2000_0004}, // R4
        '{1'b1, 1'b0, 32'hC000_1234, 1'b1, 3'b100, 1'b0, 32'hC000_1234}, // R3 R9
        '{1'b1, 1'b0, 32'h8000_0ABC, 1'b0, 3'b000, 1'b0, 32'h8000_0ABC}, // R10
        '{1'b1, 1'b1, 32'h0010_0000, 1'b0, 3'b000, 1'b0, 32'h0010_0000}, // R5
        '{1'b0, 1'b0, 32'h0010_0000, 1'b0, 3'b000, 1'b0, 32'h0010_0000}  // R10
    };

    task automatic cfg_write(input logic side, input logic [1:0] win,
                             input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_side = side; cfg_win = win; cfg_reg = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] attr(input int code, input logic pf, input logic io);
        logic [31:0] a;
        a = 32'(code) & 32'h3F;
        a[8] = pf;
        a[9] = io;
        return a;
    endfunction

    task automatic check(input string req, input logic e_fwd, input logic [2:0] e_hit,
                         input logic e_pf, input logic [31:0] e_addr);
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_fwd !== e_fwd || rsp_hit !== e_hit ||
            rsp_pf !== e_pf || rsp_addr !== e_addr) begin
            n_bad++;
            $display("FAIL %s: got v=%b fwd=%b hit=%b pf=%b addr=%h, exp v=1 fwd=%b hit=%b pf=%b addr=%h",
                     req, rsp_valid, rsp_fwd, rsp_hit, rsp_pf, rsp_addr,
                     e_fwd, e_hit, e_pf, e_addr);
        end
    endtask

    task automatic request(input logic dir, input logic io, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_dir = dir; req_io = io; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_fwd !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 reset: got v=%b fwd=%b, exp v=0 fwd=0", rsp_valid, rsp_fwd);
        end
        rst = 1'b0;

        // R2: all windows disabled after reset
        request(1'b0, 1'b0, 32'h0000_0000);
        check("R2 down after reset", 1'b0, 3'b000, 1'b0, 32'h0000_0000);
        request(1'b1, 1'b1, 32'h0000_0000);
        check("R2 up after reset", 1'b0, 3'b000, 1'b0, 32'h0000_0000);

        // Primary bank
        cfg_write(1'b0, 2'd0, 2'd0, 32'h8000_0000);
        cfg_write(1'b0, 2'd0, 2'd1, attr(1, 1'b0, 1'b0));
        cfg_write(1'b0, 2'd0, 2'd2, 32'h1000_0000);
        cfg_write(1'b0, 2'd1, 2'd0, 32'h8000_0000);
        cfg_write(1'b0, 2'd1, 2'd1, attr(9, 1'b1, 1'b0));
        cfg_write(1'b0, 2'd1, 2'd2, 32'hF000_0000);
        cfg_write(1'b0, 2'd2, 2'd0, 32'h0000_C000);
        cfg_write(1'b0, 2'd2, 2'd1, attr(2, 1'b0, 1'b1));
        cfg_write(1'b0, 2'd2, 2'd2, 32'h0000_0100);
        // Secondary bank; offset write must have no effect (R9)
        cfg_write(1'b1, 2'd0, 2'd0, 32'h0010_0000);
        cfg_write(1'b1, 2'd0, 2'd1, attr(5, 1'b1, 1'b0));
        cfg_write(1'b1, 2'd0, 2'd2, 32'h0000_5555);
        cfg_write(1'b1, 2'd1, 2'd0, 32'h2000_0000);
        cfg_write(1'b1, 2'd1, 2'd1, attr(0, 1'b1, 1'b0));
        cfg_write(1'b1, 2'd2, 2'd0, 32'hC000_0000);
        cfg_write(1'b1, 2'd2, 2'd1, attr(19, 1'b0, 1'b0));
        // Out-of-range index write is ignored
        cfg_write(1'b0, 2'd3, 2'd1, attr(20, 1'b1, 1'b0));

        for (int i = 0; i < NVEC; i++) begin
            request(VEC[i].dir, VEC[i].io, VEC[i].addr);
            check($sformatf("R3-vector %0d", i), VEC[i].fwd, VEC[i].hit, VEC[i].pf, VEC[i].xaddr);
        end

        // R1: idle cycle yields no result
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_fwd !== 1'b0 || rsp_hit !== 3'b000) begin
            n_bad++;
            $display("FAIL R1 idle: got v=%b fwd=%b hit=%b, exp 0 0 000", rsp_valid, rsp_fwd, rsp_hit);
        end

        // R1: back-to-back requests, each result one cycle later
        @(negedge clk);
        req_valid = 1'b1; req_dir = 1'b0; req_io = 1'b1; req_addr = 32'h0000_C000;
        @(negedge clk);
        check("R1 pipe first", 1'b1, 3'b100, 1'b0, 32'h0000_C100);
        req_dir = 1'b1; req_io = 1'b0; req_addr = 32'h0010_0000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 pipe second", 1'b1, 3'b001, 1'b1, 32'h0010_0000);

        // R3: base low bits are ignored
        cfg_write(1'b0, 2'd0, 2'd0, 32'h8000_0FFF);
        request(1'b0, 1'b0, 32'h8000_0001);
        check("R3 unaligned base", 1'b1, 3'b001, 1'b0, 32'h9000_0001);

        // R4 R6: disable window 0, window 1 now claims
        cfg_write(1'b0, 2'd0, 2'd1, attr(0, 1'b0, 1'b0));
        request(1'b0, 1'b0, 32'h8000_0ABC);
        check("R4 R6 fallthrough", 1'b1, 3'b010, 1'b1, 32'h7000_0ABC);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule